// File: doc/BRIEF.md
# E1 Receive Spare-Bit Extractor

This block sits behind the frame aligner on the receive side of an E1 framer and pulls out the international and national spare bits carried in timeslot 0. It runs on a system clock that is several times the line bit rate. A one-cycle `bit_en` strobe marks the start of each received bit period. The aligner also supplies a frame-start marker, together with a flag that says whether the starting frame is the align frame or the non-align frame.

The block repeats every received bit on a serial link-data output, and it drives a gated link clock. That clock rises in mid-bit, and only in bit periods that carry a national bit the host has selected. External logic can therefore latch just the national bits it needs. A sync output marks the international-bit position. It marks every frame or only the align frame, depending on a mode input.

Once per double frame, the timeslot-0 octets of both frames are published together into two host-readable registers. A sticky ready flag is raised at the same time. The host then has one double frame to read both octets before they are replaced.

Top module: `e1_spare_bit_rx`

## Requirements
- R1: `link_data` takes the value of `rx_bit` on the clock edge where `bit_en` is high and holds it until the next `bit_en`.
- R2: `link_clk` is low during the first half of every bit period (phase counted in clocks after the `bit_en` edge is below CLKS_PER_BIT/2) and high in the second half of every selected bit period. Data on `link_data` is stable when `link_clk` rises.
- R3: A bit period is selected only if it is in the non-align frame at 0-based frame position 3 to 7 and `sa_mask[position-3]` is 1. Here `sa_mask[0]` selects Sa4 and `sa_mask[4]` selects Sa8, and any combination may be enabled. In the align frame, and at every other position, `link_clk` stays low.
- R4: `sync_out` is high for the whole first bit period (the Si bit) of a frame. With `sync_mode`=0 this happens in every frame; with `sync_mode`=1 it happens only in the align frame.
- R5: `af_reg` and `naf_reg` hold timeslot 0 of the align frame and of the non-align frame exactly as received. Bit 7 of each register is the first received bit (Si) and bit 0 is the eighth.
- R6: Both registers update on the same clock edge, and `rdy_flag` sets on that edge. That edge is two clock edges after the `bit_en` edge of the eighth non-align timeslot-0 bit, so the flag is still low one clock after that `bit_en` edge.
- R7: A publish happens only when the non-align frame directly follows a captured align frame. A non-align frame that follows another non-align frame changes neither register nor the flag.
- R8: Between publishes the host registers keep their values, even while the next align octet is being captured.
- R9: `rdy_flag` stays set until `flag_clr` is 1 on a clock edge. A new publish in the same cycle as a clear leaves the flag set.
- R10: After reset all outputs are 0. Until the first `frm_start`, `link_clk` and `sync_out` stay low and nothing is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, CLKS_PER_BIT cycles per line bit |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | One-cycle strobe at the start of each received bit |
| rx_bit | input | 1 | Received serial data, valid with `bit_en` |
| frm_start | input | 1 | With `bit_en`: this bit is bit 1 of a frame |
| frm_is_align | input | 1 | With `frm_start`: 1 = align frame, 0 = non-align frame |
| sync_mode | input | 1 | 0 = sync on every frame, 1 = align frame only |
| sa_mask | input | 5 | National-bit select, bit 0 = Sa4 ... bit 4 = Sa8 |
| flag_clr | input | 1 | Write-one clear of `rdy_flag` |
| link_data | output | 1 | Every received bit, held for one bit period |
| link_clk | output | 1 | Gated strobe clock for the selected national bits |
| sync_out | output | 1 | Si position marker |
| af_reg | output | 8 | Align-frame timeslot 0 |
| naf_reg | output | 8 | Non-align-frame timeslot 0 |
| rdy_flag | output | 1 | Sticky new-data flag |

## Verification
The bench builds the block with FRAME_BITS=16 and CLKS_PER_BIT=4. A short frame means the run can cover dozens of double frames, and every mask combination in the table, within a few thousand clocks. With four clocks per bit, each bit period has distinct low-half and high-half sample points, and the two-edge delay from the last timeslot-0 bit to the flag can be observed one clock at a time. Timeslot 0 still spans eight positions, so the national-bit positions and the register bit order are exactly those of a full-length frame.

// File: rtl/e1sb_pkg.sv
package e1sb_pkg;

    localparam int TS0_LEN  = 8;   // bits in timeslot 0
    localparam int SA_FIRST = 3;   // 0-based frame position of Sa4
    localparam int SA_NUM   = 5;   // Sa4..Sa8

    typedef enum logic {
        FRM_NONALIGN = 1'b0,
        FRM_ALIGN    = 1'b1
    } frm_kind_t;

    typedef enum logic {
        SYNC_EACH = 1'b0,
        SYNC_PAIR = 1'b1
    } sync_mode_t;

    // Context of the bit period currently on link_data
    typedef struct packed {
        logic      valid;    // framer position known
        frm_kind_t kind;     // align or non-align frame
        logic      in_ts0;   // bit lies in timeslot 0
        logic [2:0] idx;     // position inside timeslot 0
    } bit_ctx_t;

    function automatic logic sa_pick(input logic [2:0] idx,
                                     input logic [SA_NUM-1:0] mask);
        logic r;
        r = 1'b0;
        for (int k = 0; k < SA_NUM; k++) begin
            if (idx == 3'(SA_FIRST + k)) r = mask[k];
        end
        return r;
    endfunction

endpackage

// File: rtl/e1sb_timing.sv
module e1sb_timing
    import e1sb_pkg::*;
#(
    parameter int FRAME_BITS   = 256,
    parameter int CLKS_PER_BIT = 8
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     bit_en,
    input  logic     rx_bit,
    input  logic     frm_start,
    input  logic     frm_is_align,
    output bit_ctx_t ctx,
    output logic     tick,
    output logic     half_hi,
    output logic     link_data
);

    localparam int CW  = $clog2(FRAME_BITS);
    localparam int PHW = $clog2(CLKS_PER_BIT);
    localparam logic [CW-1:0]  POS_LAST = CW'(FRAME_BITS - 1);
    localparam logic [PHW-1:0] PH_MAX   = PHW'(CLKS_PER_BIT - 1);
    localparam logic [PHW-1:0] PH_HALF  = PHW'(CLKS_PER_BIT / 2);

    logic [CW-1:0]  pos_q;
    logic [PHW-1:0] phase_q;
    frm_kind_t      kind_q;
    logic           locked_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q     <= '0;
            phase_q   <= '0;
            kind_q    <= FRM_NONALIGN;
            locked_q  <= 1'b0;
            tick      <= 1'b0;
            link_data <= 1'b0;
        end else begin
            tick <= bit_en;
            if (bit_en) begin
                link_data <= rx_bit;
                phase_q   <= '0;
                if (frm_start) begin
                    pos_q    <= '0;
                    kind_q   <= frm_kind_t'(frm_is_align);
                    locked_q <= 1'b1;
                end else if (locked_q) begin
                    if (pos_q == POS_LAST) begin
                        pos_q  <= '0;
                        kind_q <= (kind_q == FRM_ALIGN) ? FRM_NONALIGN : FRM_ALIGN;
                    end else begin
                        pos_q <= pos_q + 1'b1;
                    end
                end
            end else if (phase_q != PH_MAX) begin
                phase_q <= phase_q + 1'b1;
            end
        end
    end

    always_comb begin
        ctx.valid  = locked_q;
        ctx.kind   = kind_q;
        ctx.in_ts0 = (pos_q < CW'(TS0_LEN));
        ctx.idx    = pos_q[2:0];
        half_hi    = (phase_q >= PH_HALF);
    end

endmodule

// File: rtl/e1sb_strobe.sv
module e1sb_strobe
    import e1sb_pkg::*;
(
    input  bit_ctx_t          ctx,
    input  logic              half_hi,
    input  sync_mode_t        mode,
    input  logic [SA_NUM-1:0] sa_mask,
    output logic              link_clk,
    output logic              sync_out
);

    always_comb begin
        link_clk = ctx.valid && (ctx.kind == FRM_NONALIGN) && ctx.in_ts0
                   && sa_pick(ctx.idx, sa_mask) && half_hi;
        sync_out = ctx.valid && ctx.in_ts0 && (ctx.idx == 3'd0)
                   && ((mode == SYNC_EACH) || (ctx.kind == FRM_ALIGN));
    end

endmodule

// File: rtl/e1sb_capture.sv
module e1sb_capture
    import e1sb_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    input  bit_ctx_t ctx,
    input  logic     link_data,
    input  logic     flag_clr,
    output logic [TS0_LEN-1:0] af_reg,
    output logic [TS0_LEN-1:0] naf_reg,
    output logic     rdy_flag
);

    logic [TS0_LEN-1:0] shift_q, shift_n;
    logic [TS0_LEN-1:0] af_sh, naf_sh;
    logic               af_ok, pend;

    assign shift_n = {shift_q[TS0_LEN-2:0], link_data};

    always_ff @(posedge clk) begin
        if (rst) begin
            shift_q  <= '0;
            af_sh    <= '0;
            naf_sh   <= '0;
            af_ok    <= 1'b0;
            pend     <= 1'b0;
            af_reg   <= '0;
            naf_reg  <= '0;
            rdy_flag <= 1'b0;
        end else begin
            pend <= 1'b0;
            if (tick && ctx.valid && ctx.in_ts0) begin
                shift_q <= shift_n;
                if (ctx.idx == 3'(TS0_LEN - 1)) begin
                    if (ctx.kind == FRM_ALIGN) begin
                        af_sh <= shift_n;
                        af_ok <= 1'b1;
                    end else begin
                        naf_sh <= shift_n;
                        pend   <= af_ok;
                        af_ok  <= 1'b0;
                    end
                end
            end
            if (pend) begin
                af_reg   <= af_sh;
                naf_reg  <= naf_sh;
                rdy_flag <= 1'b1;
            end else if (flag_clr) begin
                rdy_flag <= 1'b0;
            end
        end
    end

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !pend |=> ($stable(af_reg) && $stable(naf_reg)));

    // R9
    sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (rdy_flag && !flag_clr) |=> rdy_flag);

endmodule

// File: rtl/e1_spare_bit_rx.sv
module e1_spare_bit_rx
    import e1sb_pkg::*;
#(
    parameter int FRAME_BITS   = 256,
    parameter int CLKS_PER_BIT = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bit_en,
    input  logic       rx_bit,
    input  logic       frm_start,
    input  logic       frm_is_align,
    input  logic       sync_mode,
    input  logic [4:0] sa_mask,
    input  logic       flag_clr,
    output logic       link_data,
    output logic       link_clk,
    output logic       sync_out,
    output logic [7:0] af_reg,
    output logic [7:0] naf_reg,
    output logic       rdy_flag
);

    bit_ctx_t ctx;
    logic     tick, half_hi;

    e1sb_timing #(
        .FRAME_BITS  (FRAME_BITS),
        .CLKS_PER_BIT(CLKS_PER_BIT)
    ) u_timing (
        .clk         (clk),
        .rst         (rst),
        .bit_en      (bit_en),
        .rx_bit      (rx_bit),
        .frm_start   (frm_start),
        .frm_is_align(frm_is_align),
        .ctx         (ctx),
        .tick        (tick),
        .half_hi     (half_hi),
        .link_data   (link_data)
    );

    e1sb_strobe u_strobe (
        .ctx     (ctx),
        .half_hi (half_hi),
        .mode    (sync_mode_t'(sync_mode)),
        .sa_mask (sa_mask),
        .link_clk(link_clk),
        .sync_out(sync_out)
    );

    e1sb_capture u_capture (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .ctx      (ctx),
        .link_data(link_data),
        .flag_clr (flag_clr),
        .af_reg   (af_reg),
        .naf_reg  (naf_reg),
        .rdy_flag (rdy_flag)
    );

    // R2
    tick_low_chk: assert property (@(posedge clk) disable iff (rst)
        tick |-> !link_clk);

    // R2
    data_stable_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(link_clk) |-> $stable(link_data));

    // R6
    pub_flag_chk: assert property (@(posedge clk) disable iff (rst)
        ((af_reg != $past(af_reg)) || (naf_reg != $past(naf_reg))) |-> rdy_flag);

endmodule

// File: tb/sim_e1_spare_bit_rx.sv
module sim_e1_spare_bit_rx;

    localparam int FB  = 16;
    localparam int CPB = 4;

    logic clk = 1'b0;
    logic rst, bit_en, rx_bit, frm_start, frm_is_align, sync_mode, flag_clr;
    logic [4:0] sa_mask;
    logic link_data, link_clk, sync_out, rdy_flag;
    logic [7:0] af_reg, naf_reg;

    int checks = 0;
    int errors = 0;

    logic s_data, s_lc1, s_lc3, s_sync, s_fl1, s_fl3;

    // {mask, align octet, non-align octet}
    localparam logic [20:0] VEC [6] = '{
        {5'b00001, 8'h9B, 8'h5F},
        {5'b10000, 8'h1B, 8'h40},
        {5'b10101, 8'h9B, 8'h6A},
        {5'b01010, 8'h1B, 8'h55},
        {5'b11111, 8'h9B, 8'h7F},
        {5'b00000, 8'h1B, 8'hC3}
    };

    always #2 clk = ~clk;

    e1_spare_bit_rx #(.FRAME_BITS(FB), .CLKS_PER_BIT(CPB)) u0 (
        .clk(clk), .rst(rst), .bit_en(bit_en), .rx_bit(rx_bit),
        .frm_start(frm_start), .frm_is_align(frm_is_align),
        .sync_mode(sync_mode), .sa_mask(sa_mask), .flag_clr(flag_clr),
        .link_data(link_data), .link_clk(link_clk), .sync_out(sync_out),
        .af_reg(af_reg), .naf_reg(naf_reg), .rdy_flag(rdy_flag)
    );

    task automatic chk(input string rq, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic send_bit(input logic b, input logic fs, input logic al);
        @(negedge clk);
        bit_en = 1'b1; rx_bit = b; frm_start = fs; frm_is_align = al;
        @(negedge clk);
        bit_en = 1'b0; frm_start = 1'b0;
        s_data = link_data; s_lc1 = link_clk; s_sync = sync_out; s_fl1 = rdy_flag;
        @(negedge clk);
        @(negedge clk);
        s_lc3 = link_clk; s_fl3 = rdy_flag;
    endtask

    task automatic send_frame(input logic [7:0] oct, input logic al, input logic exp_pub);
        for (int i = 0; i < FB; i++) begin
            logic bt, exp_lc, exp_sy;
            bt     = (i < 8) ? oct[7-i] : logic'((i % 3) == 0);
            exp_lc = (!al && i >= 3 && i <= 7) ? sa_mask[i-3] : 1'b0;
            exp_sy = (i == 0) && (!sync_mode || al);
            send_bit(bt, i == 0, al);
            chk("R1 link_data", s_data, bt);
            chk("R2 link_clk first half", s_lc1, 0);
            chk("R3 link_clk second half", s_lc3, exp_lc);
            chk("R4 sync_out", s_sync, exp_sy);
            if (exp_pub && i == 7) begin
                chk("R6 flag one clock after", s_fl1, 0);
                chk("R6 flag after publish", s_fl3, 1);
            end
        end
    endtask

    task automatic clear_flag();
        @(negedge clk); flag_clr = 1'b1;
        @(negedge clk); flag_clr = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; bit_en = 1'b0; rx_bit = 1'b0; frm_start = 1'b0;
        frm_is_align = 1'b0; sync_mode = 1'b0; sa_mask = 5'b11111; flag_clr = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk("R10 link_data reset", link_data, 0);
        chk("R10 link_clk reset", link_clk, 0);
        chk("R10 sync reset", sync_out, 0);
        chk("R10 af_reg reset", af_reg, 0);
        chk("R10 naf_reg reset", naf_reg, 0);
        chk("R10 flag reset", rdy_flag, 0);

        // R10 no strobes before the first frame start
        for (int i = 0; i < FB; i++) begin
            send_bit(logic'(i % 2), 1'b0, 1'b0);
            chk("R10 link_clk before lock", s_lc3, 0);
            chk("R10 sync before lock", s_sync, 0);
        end
        chk("R10 no capture before lock", rdy_flag, 0);

        // Table walk: R1 to R6
        for (int v = 0; v < 6; v++) begin
            sa_mask = VEC[v][20:16];
            send_frame(VEC[v][15:8], 1'b1, 1'b0);
            send_frame(VEC[v][7:0], 1'b0, 1'b1);
            chk("R5 af_reg", af_reg, VEC[v][15:8]);
            chk("R5 naf_reg", naf_reg, VEC[v][7:0]);
            chk("R6 flag set", rdy_flag, 1);
            clear_flag();
            chk("R9 flag cleared", rdy_flag, 0);
        end

        // R7: non-align after non-align does not publish
        sa_mask = 5'b01101;
        send_frame(8'h5A, 1'b0, 1'b0);
        send_frame(8'h66, 1'b0, 1'b0);
        chk("R7 flag stays low", rdy_flag, 0);
        chk("R7 af_reg kept", af_reg, 8'h1B);
        chk("R7 naf_reg kept", naf_reg, 8'hC3);

        // R8 and R4 in align-only sync mode
        sync_mode = 1'b1;
        send_frame(8'h9B, 1'b1, 1'b0);
        chk("R8 af_reg held during capture", af_reg, 8'h1B);
        chk("R8 naf_reg held during capture", naf_reg, 8'hC3);
        send_frame(8'h71, 1'b0, 1'b1);
        chk("R5 af_reg new pair", af_reg, 8'h9B);
        chk("R5 naf_reg new pair", naf_reg, 8'h71);

        // R9: sticky without a clear
        send_frame(8'h1B, 1'b1, 1'b0);
        chk("R9 flag sticky", rdy_flag, 1);
        chk("R8 af_reg held", af_reg, 8'h9B);
        @(negedge clk);
        chk("R9 flag sticky idle", rdy_flag, 1);
        clear_flag();
        chk("R9 flag cleared by write", rdy_flag, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule